// File: doc/BRIEF.md
# Frequency-Lock Regulator for a Trimmable Fast Oscillator

This block keeps a fast on-chip oscillator at a whole multiple of a slower timer input clock. It runs on the fast clock and samples the timer input clock as asynchronous data. A synchronizer turns each rising edge of that input into a one-cycle pulse. The block counts fast-clock cycles between two such pulses and compares that count with the selected multiple, which is either 8 or 16. After every counting window it moves an 8-bit trim code by at most one step. The trim code goes back to the oscillator, which closes the loop.

The block reports four status outputs. A live "unlocked" level is high whenever the loop is not in lock. A sticky lock flag is set when lock is gained. Two sticky range flags are set when the trim code is already at its top or bottom and the count still misses the target in that direction. A three-bit strobe clears the sticky flags. While the enable input is low, the block makes no trim updates and holds the last code, so the oscillator runs free at that setting.

No data stream crosses the boundary, so there is no valid/ready handshake. Every pin is a plain control or status level, and the enable, mode and clear inputs are synchronous to the fast clock.

Top module: `flr_regulator`

## Requirements
- R1: After reset, trim_o is 128 (mid-scale), lock_flag_o, fail_hi_o and fail_lo_o are 0, and unlocked_o is 1.
- R2: The input ref_clk_i passes through two flops and one edge-detect flop. A counting window is the number of fast cycles between two consecutive detected rising edges. The first detected edge after enabling only opens a window and does not cause an evaluation.
- R3: The target count is 8 when mode_x16_i is 0 and 16 when mode_x16_i is 1.
- R4: At the end of each evaluated window, trim_o changes as follows:
  - it decreases by 1 when the count is above the target;
  - it increases by 1 when the count is below the target;
  - it is unchanged when the count equals the target;
  - it changes at no other time.
- R5: trim_o clamps at 0 and 255 and never wraps.
- R6: The loop enters lock at the end of the 4th consecutive evaluated window whose count equals the target exactly.
- R7: A locked loop leaves lock at the end of the 2nd consecutive evaluated window whose count differs from the target by more than 1.
- R8: unlocked_o is a live level: it is 1 whenever the loop is not locked, and it changes in the same cycle as the internal lock state.
- R9: fail_hi_o becomes 1 after an evaluated window whose count is below the target while trim_o is 255. It stays 1 until cleared.
- R10: fail_lo_o becomes 1 after an evaluated window whose count is above the target while trim_o is 0. It stays 1 until cleared.
- R11: lock_flag_o becomes 1 in the cycle the loop enters lock. It stays 1 until cleared, and losing lock does not clear it.
- R12: flag_clr_i clears the sticky flags one cycle after it is sampled:
  - bit 0 clears lock_flag_o;
  - bit 1 clears fail_hi_o;
  - bit 2 clears fail_lo_o;
  - if a flag is set and cleared in the same cycle, the set wins.
- R13: While reg_en_i is 0, trim_o is held. The loop also leaves lock and its match and miss streaks restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast oscillator clock; all logic runs on it |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Timer input clock, sampled asynchronously |
| reg_en_i | input | 1 | Regulation enable |
| mode_x16_i | input | 1 | Target select: 0 = x8, 1 = x16 |
| flag_clr_i | input | 3 | Clear strobes for lock, fail-high and fail-low flags |
| trim_o | output | 8 | Trim code to the oscillator |
| unlocked_o | output | 1 | Live not-locked level |
| lock_flag_o | output | 1 | Sticky lock-gained flag |
| fail_hi_o | output | 1 | Sticky input-too-fast flag |
| fail_lo_o | output | 1 | Sticky input-too-slow flag |

## Verification
The assertions assume the following about the inputs:
- reg_en_i, mode_x16_i and flag_clr_i change only between fast-clock edges;
- every high phase and every low phase of ref_clk_i lasts at least two fast cycles, so the synchronizer sees each rising edge exactly once.

The stimulus meets these assumptions as follows:
- all controls are driven on falling edges;
- the timer clock comes from a model whose period is an offset plus trim/16 fast cycles, clamped to 4 to 60 cycles, with a half-period high phase.

The offset is changed to force retracking, loss of lock, and saturation at each end of the trim range.

// File: rtl/flr_pkg.sv
package flr_pkg;

  // Outcome of one counting window against the target multiple.
  typedef struct packed {
    logic over;   // count above target
    logic under;  // count below target
    logic exact;  // count equals target
    logic far;    // count misses by more than one
  } win_cls_t;

  // Bit positions within the clear strobe.
  localparam int CLR_LOCK = 0;
  localparam int CLR_FHI  = 1;
  localparam int CLR_FLO  = 2;

endpackage

// File: rtl/flr_edge_sync.sv
module flr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Shift the asynchronous level through STAGES flops, then keep one more
  // copy so a rising transition can be seen as a single-cycle pulse.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/flr_window.sv
module flr_window
  import flr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TGT_LO = 8,
  parameter int TGT_HI = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rise_i,
  input  logic     en_i,
  input  logic     mode_x16_i,
  output logic     eval_o,
  output win_cls_t cls_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W:0]   EXT_ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;
  logic [CNT_W-1:0] tgt;
  logic [CNT_W:0]   cnt_ext;
  logic [CNT_W:0]   tgt_ext;

  // Cycle counter: restarts at one on each edge, saturates at the top.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (rise_i) begin
      cnt_q <= CNT_ONE;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  // A window is only trusted once an edge has been seen while enabled.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
    end else if (!en_i) begin
      primed_q <= 1'b0;
    end else if (rise_i) begin
      primed_q <= 1'b1;
    end
  end

  assign tgt     = mode_x16_i ? CNT_W'(TGT_HI) : CNT_W'(TGT_LO);
  assign cnt_ext = {1'b0, cnt_q};
  assign tgt_ext = {1'b0, tgt};
  assign eval_o  = rise_i & en_i & primed_q;

  always_comb begin
    cls_o.over  = cnt_q > tgt;
    cls_o.under = cnt_q < tgt;
    cls_o.exact = cnt_q == tgt;
    cls_o.far   = (cnt_ext > tgt_ext + EXT_ONE) || (tgt_ext > cnt_ext + EXT_ONE);
  end

endmodule

// File: rtl/flr_trim.sv
module flr_trim #(
  parameter int TRIM_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              eval_i,
  input  logic              over_i,
  input  logic              under_i,
  output logic [TRIM_W-1:0] trim_o
);

  localparam logic [TRIM_W-1:0] T_MAX = {TRIM_W{1'b1}};
  localparam logic [TRIM_W-1:0] T_MID = TRIM_W'(1) << (TRIM_W-1);
  localparam logic [TRIM_W-1:0] T_ONE = TRIM_W'(1);

  logic [TRIM_W-1:0] trim_q;
  logic [TRIM_W-1:0] trim_d;

  always_comb begin
    trim_d = trim_q;
    if (eval_i && over_i && trim_q != '0) begin
      trim_d = trim_q - T_ONE;
    end else if (eval_i && under_i && trim_q != T_MAX) begin
      trim_d = trim_q + T_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q <= T_MID;
    end else begin
      trim_q <= trim_d;
    end
  end

  assign trim_o = trim_q;

  // R4: any change is a single step, and only after a window ends
  p_step_one_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_q != $past(trim_q)) |->
      ((trim_q == $past(trim_q) + T_ONE) || (trim_q == $past(trim_q) - T_ONE)));
  p_step_on_eval_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_q != $past(trim_q)) |-> $past(eval_i));
  // R5: no wrap at either end
  p_no_wrap_top_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(trim_q) == T_MAX) |-> (trim_q != '0));
  p_no_wrap_bot_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(trim_q) == '0) |-> (trim_q != T_MAX));
  // R13: held while regulation is off
  p_hold_off_r13 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(trim_q));

endmodule

// File: rtl/flr_lock_mon.sv
module flr_lock_mon #(
  parameter int LOCK_WINS = 4,
  parameter int LOSS_WINS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic eval_i,
  input  logic exact_i,
  input  logic far_i,
  output logic locked_o,
  output logic lock_set_o
);

  localparam int RW = $clog2(LOCK_WINS + 1);
  localparam int MW = $clog2(LOSS_WINS + 1);
  localparam logic [RW-1:0] RUN_SAT  = RW'(LOCK_WINS);
  localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_WINS - 1);
  localparam logic [MW-1:0] MISS_SAT  = MW'(LOSS_WINS);
  localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_WINS - 1);

  logic [RW-1:0] run_q, run_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          locked_q, locked_d;
  logic          gain, loss;

  assign gain = eval_i && exact_i && !locked_q && (run_q == RUN_LAST);
  assign loss = eval_i && far_i && locked_q && (miss_q == MISS_LAST);

  always_comb begin
    run_d    = run_q;
    miss_d   = miss_q;
    locked_d = locked_q;
    if (!en_i) begin
      run_d    = '0;
      miss_d   = '0;
      locked_d = 1'b0;
    end else if (eval_i) begin
      if (exact_i) begin
        run_d = (run_q == RUN_SAT) ? run_q : run_q + RW'(1);
      end else begin
        run_d = '0;
      end
      if (far_i) begin
        miss_d = (miss_q == MISS_SAT) ? miss_q : miss_q + MW'(1);
      end else begin
        miss_d = '0;
      end
      if (gain) begin
        locked_d = 1'b1;
      end else if (loss) begin
        locked_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      miss_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      miss_q   <= miss_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o   = locked_q;
  assign lock_set_o = gain && en_i;

  // R6: lock is only entered at the end of an exact window
  p_lock_on_exact_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(eval_i && exact_i));
  // R7: lock is only dropped by a far window or by disabling
  p_loss_cause_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> $past((eval_i && far_i) || !en_i));
  // R13: disabling always clears the lock state
  p_drop_when_off_r13 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !locked_q);

endmodule

// File: rtl/flr_status.sv
module flr_status
  import flr_pkg::*;
#(
  parameter int TRIM_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic              over_i,
  input  logic              under_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              lock_set_i,
  input  logic [2:0]        clr_i,
  output logic              lock_flag_o,
  output logic              fail_hi_o,
  output logic              fail_lo_o
);

  localparam logic [TRIM_W-1:0] T_MAX = {TRIM_W{1'b1}};

  logic set_hi, set_lo;
  logic lk_q, hi_q, lo_q;

  assign set_hi = eval_i && under_i && (trim_i == T_MAX);
  assign set_lo = eval_i && over_i && (trim_i == '0);

  // Set has priority over the clear strobe.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_q <= 1'b0;
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      lk_q <= lock_set_i | (lk_q & ~clr_i[CLR_LOCK]);
      hi_q <= set_hi     | (hi_q & ~clr_i[CLR_FHI]);
      lo_q <= set_lo     | (lo_q & ~clr_i[CLR_FLO]);
    end
  end

  assign lock_flag_o = lk_q;
  assign fail_hi_o   = hi_q;
  assign fail_lo_o   = lo_q;

  // R9: fail-high only while the trim code sits at the top
  p_fail_hi_at_top_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_q) |-> $past(trim_i == T_MAX));
  // R10: fail-low only while the trim code sits at the bottom
  p_fail_lo_at_bottom_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_q) |-> $past(trim_i == '0));
  // R12: a flag only falls after its clear bit
  p_clear_hi_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hi_q) |-> $past(clr_i[CLR_FHI]));

endmodule

// File: rtl/flr_regulator.sv
module flr_regulator
  import flr_pkg::*;
#(
  parameter int TRIM_W    = 8,
  parameter int CNT_W     = 8,
  parameter int SYNC_STG  = 2,
  parameter int TGT_LO    = 8,
  parameter int TGT_HI    = 16,
  parameter int LOCK_WINS = 4,
  parameter int LOSS_WINS = 2
) (
  input  logic              clk_fast_i,
  input  logic              rst_n_i,
  input  logic              ref_clk_i,
  input  logic              reg_en_i,
  input  logic              mode_x16_i,
  input  logic [2:0]        flag_clr_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              unlocked_o,
  output logic              lock_flag_o,
  output logic              fail_hi_o,
  output logic              fail_lo_o
);

  logic     rise;
  logic     eval;
  win_cls_t cls;
  logic     locked;
  logic     lock_set;

  flr_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_fast_i),
    .rst_ni (rst_n_i),
    .async_i(ref_clk_i),
    .rise_o (rise)
  );

  flr_window #(.CNT_W(CNT_W), .TGT_LO(TGT_LO), .TGT_HI(TGT_HI)) u_win (
    .clk_i     (clk_fast_i),
    .rst_ni    (rst_n_i),
    .rise_i    (rise),
    .en_i      (reg_en_i),
    .mode_x16_i(mode_x16_i),
    .eval_o    (eval),
    .cls_o     (cls)
  );

  flr_trim #(.TRIM_W(TRIM_W)) u_trim (
    .clk_i  (clk_fast_i),
    .rst_ni (rst_n_i),
    .en_i   (reg_en_i),
    .eval_i (eval),
    .over_i (cls.over),
    .under_i(cls.under),
    .trim_o (trim_o)
  );

  flr_lock_mon #(.LOCK_WINS(LOCK_WINS), .LOSS_WINS(LOSS_WINS)) u_lock (
    .clk_i     (clk_fast_i),
    .rst_ni    (rst_n_i),
    .en_i      (reg_en_i),
    .eval_i    (eval),
    .exact_i   (cls.exact),
    .far_i     (cls.far),
    .locked_o  (locked),
    .lock_set_o(lock_set)
  );

  flr_status #(.TRIM_W(TRIM_W)) u_stat (
    .clk_i      (clk_fast_i),
    .rst_ni     (rst_n_i),
    .eval_i     (eval),
    .over_i     (cls.over),
    .under_i    (cls.under),
    .trim_i     (trim_o),
    .lock_set_i (lock_set),
    .clr_i      (flag_clr_i),
    .lock_flag_o(lock_flag_o),
    .fail_hi_o  (fail_hi_o),
    .fail_lo_o  (fail_lo_o)
  );

  assign unlocked_o = ~locked;

endmodule

// File: tb/flr_regulator_tb_top.sv
`timescale 1ns/1ps
module flr_regulator_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       reg_en = 1'b0;
  logic       mode_x16 = 1'b0;
  logic [2:0] flag_clr = 3'b000;
  logic [7:0] trim;
  logic       unlocked, lock_flag, fail_hi, fail_lo;

  integer checks = 0;
  integer errors = 0;
  bit     done = 1'b0;
  integer osc_off = 2;
  bit     gen_on = 1'b1;

  always #2.5 clk = ~clk;

  flr_regulator dut_i (
    .clk_fast_i (clk),
    .rst_n_i    (rst_n),
    .ref_clk_i  (ref_clk),
    .reg_en_i   (reg_en),
    .mode_x16_i (mode_x16),
    .flag_clr_i (flag_clr),
    .trim_o     (trim),
    .unlocked_o (unlocked),
    .lock_flag_o(lock_flag),
    .fail_hi_o  (fail_hi),
    .fail_lo_o  (fail_lo)
  );

  task automatic chk(input bit ok, input string tag, input integer act, input integer exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural oscillator: timer period in fast cycles follows the trim code.
  integer ph = 0;
  integer per = 8;
  always @(negedge clk) begin
    if (gen_on) begin
      if (ph == 0) begin
        per = osc_off + integer'(trim) / 16;
        if (per < 4) per = 4;
        if (per > 60) per = 60;
        ref_clk = 1'b1;
      end else if (ph == per / 2) begin
        ref_clk = 1'b0;
      end
      ph = ph + 1;
      if (ph >= per) ph = 0;
    end
  end

  // Reference model, advanced on every rising edge from the bench's inputs.
  integer ms1, ms2, ms3, mcnt, mtrim, mrun, mmiss;
  bit     mprimed, mlocked, mflk, mfhi, mflo;
  always @(posedge clk) begin
    integer tgt, d;
    bit     pulse, ev, lset, shi, slo;
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; ms3 = 0; mcnt = 0; mtrim = 128; mrun = 0; mmiss = 0;
      mprimed = 0; mlocked = 0; mflk = 0; mfhi = 0; mflo = 0;
    end else begin
      pulse = (ms2 == 1) && (ms3 == 0);
      tgt   = mode_x16 ? 16 : 8;
      ev    = pulse && reg_en && mprimed;
      d     = mcnt - tgt;
      lset  = 0;
      shi   = ev && (d < 0) && (mtrim == 255);
      slo   = ev && (d > 0) && (mtrim == 0);
      if (!reg_en) begin
        mlocked = 0; mrun = 0; mmiss = 0;
      end else if (ev) begin
        if (d == 0) begin
          if (!mlocked && mrun == 3) begin mlocked = 1; lset = 1; end
          if (mrun < 4) mrun = mrun + 1;
        end else mrun = 0;
        if (d > 1 || d < -1) begin
          if (mlocked && mmiss == 1) mlocked = 0;
          if (mmiss < 2) mmiss = mmiss + 1;
        end else mmiss = 0;
        if (d > 0 && mtrim > 0) mtrim = mtrim - 1;
        else if (d < 0 && mtrim < 255) mtrim = mtrim + 1;
      end
      mflk = lset || (mflk && !flag_clr[0]);
      mfhi = shi  || (mfhi && !flag_clr[1]);
      mflo = slo  || (mflo && !flag_clr[2]);
      mprimed = reg_en ? (pulse || mprimed) : 0;
      if (pulse) mcnt = 1;
      else if (mcnt < 255) mcnt = mcnt + 1;
      ms3 = ms2; ms2 = ms1; ms1 = ref_clk;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(trim == mtrim[7:0], "R4 (R2,R3) trim per cycle", trim, mtrim);
      chk(unlocked == !mlocked, "R8 unlocked per cycle", unlocked, !mlocked);
      chk(lock_flag == mflk, "R11 lock flag per cycle", lock_flag, mflk);
      chk(fail_hi == mfhi, "R9 fail-high per cycle", fail_hi, mfhi);
      chk(fail_lo == mflo, "R10 fail-low per cycle", fail_lo, mflo);
    end
  end

  task automatic cyc(input integer n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input logic [2:0] v);
    @(negedge clk); flag_clr = v;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    integer held;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(trim == 8'd128, "R1 trim after reset", trim, 128);
    chk(unlocked && !lock_flag && !fail_hi && !fail_lo, "R1 flags after reset",
        {unlocked, lock_flag, fail_hi, fail_lo}, 4'b1000);

    // x8 acquisition from mid-scale
    reg_en = 1'b1; mode_x16 = 1'b0; osc_off = 2;
    cyc(600);
    chk(!unlocked, "R6 locked in x8 mode", unlocked, 0);
    chk(trim >= 8'd96 && trim <= 8'd111, "R3 x8 trim range", trim, 111);
    chk(lock_flag, "R11 lock flag set", lock_flag, 1);

    // clearing the lock flag while still locked
    pulse_clr(3'b001);
    chk(!lock_flag, "R12 lock flag cleared", lock_flag, 0);
    chk(!unlocked, "R12 lock state kept after clear", unlocked, 0);

    // input frequency shift: loss of lock, then retrack
    osc_off = 4;
    cyc(60);
    chk(unlocked, "R7 lock lost after far windows", unlocked, 1);
    chk(!lock_flag, "R11 loss does not set flag", lock_flag, 0);
    cyc(900);
    chk(!unlocked && lock_flag, "R6 relock after shift", unlocked, 0);

    // x16 target
    mode_x16 = 1'b1;
    cyc(3000);
    chk(trim >= 8'd192 && trim <= 8'd207, "R3 x16 trim range", trim, 192);
    chk(!unlocked, "R3 locked in x16 mode", unlocked, 0);

    // free-running: trim held, lock dropped
    @(negedge clk); reg_en = 1'b0; held = trim;
    osc_off = 8;
    cyc(400);
    chk(trim == held[7:0], "R13 trim held while off", trim, held);
    chk(unlocked, "R13 unlocked while off", unlocked, 1);

    // input too fast: saturate high
    osc_off = -10; reg_en = 1'b1;
    cyc(2000);
    chk(trim == 8'd255, "R5 trim clamps at 255", trim, 255);
    chk(fail_hi && !fail_lo, "R9 fail-high set", fail_hi, 1);
    @(negedge clk); reg_en = 1'b0;
    pulse_clr(3'b010);
    chk(!fail_hi, "R12 fail-high cleared", fail_hi, 0);

    // input too slow: saturate low
    osc_off = 20; mode_x16 = 1'b0; reg_en = 1'b1;
    cyc(10000);
    chk(trim == 8'd0, "R5 trim clamps at 0", trim, 0);
    chk(fail_lo && !fail_hi, "R10 fail-low set", fail_lo, 1);
    @(negedge clk); reg_en = 1'b0;
    pulse_clr(3'b100);
    chk(!fail_lo, "R12 fail-low cleared", fail_lo, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule